// File: doc/BRIEF.md
# I2C Register Slave with Broadcast Write and Stuck-Bus Watchdog

This block is an I2C target that lets a bus controller reach a sixteen-entry byte register file. A 3-bit strap picks its own 7-bit address from 0x50 to 0x57. It also answers a shared broadcast address, 0x58, so that one write can reach every such target on the bus at once. That shared address accepts writes only. SCL and SDA are oversampled by a fast system clock. The block finds START, repeated START and STOP, shifts address and data bytes, and drives acknowledge and read bits through a pull-low enable.

In a write transfer, the first byte after the address is a command byte that loads the register pointer. The bytes after it land in successive registers. A read transfer returns bytes from the current pointer. The usual way to read is therefore a write of the command byte, then a repeated START, then the read. The last entry is a status register that records whether a transfer was cut short by the watchdog. The watchdog returns the engine to idle when SDA is held low for too long.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A START seen during a transfer (a repeated START) begins a new address phase at once.
- R2: The first byte after a START holds a 7-bit address, MSB first, followed by a direction bit (0 = write, 1 = read). SDA is sampled on the SCL rising edge.
- R3: The block acknowledges its own address, 0x50 + `dev_sel`, for both directions.
- R4: Address 0x58 is acknowledged for a write, and the bytes written to it are performed. A read directed at 0x58 is not acknowledged.
- R5: After an address it does not answer, the block never pulls SDA low until the next START.
- R6: Each byte takes nine SCL pulses, and the acknowledge is driven low through the ninth pulse. `sda_oe` only ever asserts while SCL is low.
- R7: The first byte of a write transfer loads the register pointer with its low 4 bits. Every later byte is written to the register that the pointer selects. The block acknowledges all of these bytes.
- R8: A read returns bytes MSB first, starting at the pointer. When the controller answers a byte with NACK, the block releases SDA and ignores further clock pulses until a STOP or a START.
- R9: If SDA stays low for `TIMEOUT_CYC` system clocks, the engine returns to idle with SDA released, and bit 0 of the status register is set. A transfer cut off this way writes no further registers.
- R10: SDA is only ever pulled low through `sda_oe` and is never driven high. After reset, `sda_oe` is 0 and every register reads 0x00.
- R11: The pointer advances after each byte written or read, and wraps from 15 to 0.
- R12: Register 15 is the status register: bit 0 holds the timeout flag, and the other bits read 0. A write to it stores nothing and clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 3 | Address strap; own address is 0x50 plus this value |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |

## Verification
The bench drives a broadcast read and expects it to be refused. A design that treated 0x58 the same for both directions would acknowledge that read and then fight the controller on the data bits. It also writes across the end of the register file, through the status entry. A design that got the wrap or the status write wrong would spill data into register 15 or fail to clear the flag. The bench holds SDA low in the middle of a write, then clocks in a stray byte without a START. A design whose watchdog did not reset the engine would acknowledge that byte and corrupt the register. Every clock, the bench also checks that the block stays off the bus after an unmatched address or a controller NACK, and that it never starts pulling low while SCL is high.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  localparam logic [6:0] BASE_ADDR  = 7'h50;
  localparam logic [6:0] BCAST_ADDR = 7'h58;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } eng_st_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } rx_ph_t;

  function automatic logic [6:0] own_addr(input logic [2:0] sel);
    return BASE_ADDR + {4'b0000, sel};
  endfunction

  // Answer own address either way, broadcast only for writes.
  function automatic logic addr_accept(input logic [6:0] a, input logic rw,
                                       input logic [2:0] sel);
    return (a == own_addr(sel)) || ((a == BCAST_ADDR) && !rw);
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int DEPTH = STAGES + 1;

  logic [1:0] line_in;
  logic [1:0] line_now;
  logic [1:0] line_old;

  assign line_in = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_line
      logic [DEPTH-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[DEPTH-2:0], line_in[g]};
      end
      assign line_now[g] = chain[STAGES-1];
      assign line_old[g] = chain[STAGES];
    end
  endgenerate

  assign scl_lvl   = line_now[0];
  assign sda_lvl   = line_now[1];
  assign scl_rise  = line_now[0] & ~line_old[0];
  assign scl_fall  = ~line_now[0] & line_old[0];
  assign start_det = line_now[0] & line_old[0] & line_old[1] & ~line_now[1];
  assign stop_det  = line_now[0] & line_old[0] & ~line_old[1] & line_now[1];

endmodule

// File: rtl/i2c_rb_watchdog.sv
module i2c_rb_watchdog #(
  parameter int LIMIT = 65000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_lvl,
  output logic fire
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (sda_lvl)          low_cnt <= '0;
    else if (low_cnt != TOP)   low_cnt <= low_cnt + 1'b1;
  end

  assign fire = !sda_lvl && (low_cnt == LAST);

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NREG)-1:0]  widx,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0]  ridx,
  output logic [DW-1:0]            rdata,
  input  logic                     set_to
);

  localparam int PW = $clog2(NREG);
  localparam logic [PW-1:0] STAT = PW'(NREG - 1);

  logic [DW-1:0] mem [NREG-1];
  logic          to_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG - 1; i++) mem[i] <= '0;
    end else if (we && widx != STAT) begin
      mem[widx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     to_flag <= 1'b0;
    else if (set_to)                to_flag <= 1'b1;
    else if (we && widx == STAT)    to_flag <= 1'b0;
  end

  assign rdata = (ridx == STAT) ? {{(DW-1){1'b0}}, to_flag} : mem[ridx];

  p_stat_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == STAT && !set_to) |=> (rdata[0] == 1'b0 || ridx != STAT) && !to_flag);

  p_stat_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_to |=> to_flag);

endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
  import i2c_rb_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               dev_sel,
  input  logic                     scl_lvl,
  input  logic                     sda_lvl,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic                     to_fire,
  input  logic [7:0]               rd_data,
  output logic [$clog2(NREG)-1:0]  ptr,
  output logic                     wr_en,
  output logic [$clog2(NREG)-1:0]  wr_idx,
  output logic [7:0]               wr_data,
  output logic                     sda_oe
);

  localparam int PW = $clog2(NREG);

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(NREG - 1)) ? '0 : p + 1'b1;
  endfunction

  eng_st_t    st;
  rx_ph_t     phase;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rd_mode;
  logic       more;

  logic bus_evt;
  logic byte_done;
  logic tx_end;

  assign bus_evt   = to_fire | start_det | stop_det;
  assign byte_done = !bus_evt && (st == ST_RX) && scl_fall && (cnt == 4'd8);
  assign tx_end    = !bus_evt && (st == ST_TX) && scl_fall && (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      phase   <= PH_ADDR;
      cnt     <= '0;
      sh      <= '0;
      rd_mode <= 1'b0;
      more    <= 1'b0;
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (to_fire) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= ST_RX;
        phase  <= PH_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt <= '0;
              unique case (phase)
                PH_ADDR: begin
                  if (addr_accept(sh[7:1], sh[0], dev_sel)) begin
                    sda_oe  <= 1'b1;
                    rd_mode <= sh[0];
                    st      <= ST_ACK;
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                PH_CMD: begin
                  ptr    <= sh[PW-1:0];
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr_next(ptr);
                  sda_oe  <= 1'b1;
                  st      <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (phase == PH_ADDR && rd_mode) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                phase  <= (phase == PH_ADDR) ? PH_CMD : PH_DATA;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise && cnt != 4'd8) begin
              cnt <= cnt + 1'b1;
            end else if (tx_end) begin
              sda_oe <= 1'b0;
              ptr    <= ptr_next(ptr);
              more   <= 1'b0;
              st     <= ST_MACK;
            end else if (scl_fall && cnt != 4'd0) begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (!sda_lvl) more <= 1'b1;
              else          st   <= ST_WAIT;
            end else if (scl_fall && more) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              cnt    <= '0;
              st     <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_oe_rise_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  p_nomatch_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_ADDR && sh[7:1] != (7'h50 + {4'b0, dev_sel})
     && !(sh[7:1] == 7'h58 && !sh[0])) |=> !sda_oe);

  p_wait_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_oe);

  p_bcast_read_nack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_ADDR && sh == 8'hB1) |=> (!sda_oe && st == ST_WAIT));

  p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    to_fire |=> (st == ST_IDLE && !sda_oe));

  p_cmd_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_CMD) |=> ptr == $past(sh[PW-1:0]));

  p_ptr_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((byte_done && phase == PH_DATA) || tx_end) && ptr == PW'(NREG - 1) |=> ptr == '0);

  p_restart_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !to_fire) |=> (st == ST_RX && phase == PH_ADDR && cnt == 4'd0));

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int NREG        = 16,
  parameter int TIMEOUT_CYC = 65000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] dev_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);

  localparam int PW = $clog2(NREG);

  logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic          to_fire;
  logic [PW-1:0] ptr, wr_idx;
  logic          wr_en;
  logic [7:0]    wr_data, rd_data;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_rb_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .sda_lvl(sda_lvl),
    .fire   (to_fire)
  );

  i2c_rb_engine #(.NREG(NREG)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_sel  (dev_sel),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .to_fire  (to_fire),
    .rd_data  (rd_data),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe)
  );

  i2c_rb_regfile #(.NREG(NREG), .DW(8)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .widx  (wr_idx),
    .wdata (wr_data),
    .ridx  (ptr),
    .rdata (rd_data),
    .set_to(to_fire)
  );

endmodule

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb;

  localparam int CLK_NS = 10;
  localparam int Q      = 10;
  localparam int TO     = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd3;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_NS/2) clk = ~clk;

  i2c_regbank_slave #(.NREG(16), .TIMEOUT_CYC(TO), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_sel(sel),
    .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  logic [7:0] mdl [16];
  bit   mflag = 0;
  int   mptr = 0;
  bit   quiet = 0;
  bit   done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Per-clock comparison against the bench's view of when the target may drive.
  bit p_viol = 0, p_oe = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (quiet && sda_oe && !p_viol) begin
        n_fail++;
        $display("FAIL R5 bus driven while target must be silent actual=1 expected=0");
      end
      if (sda_oe && !p_oe && scl) begin
        n_fail++;
        $display("FAIL R6 pull-low began with SCL high actual=1 expected=0");
      end
      p_viol = quiet && sda_oe;
      p_oe   = sda_oe;
    end
  end

  task automatic do_start();
    sda_m = 1'b1; scl = 1'b1; hp(Q);
    sda_m = 1'b0; hp(Q);
    scl = 1'b0; hp(Q);
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; hp(Q);
    scl = 1'b1; hp(Q);
    sda_m = 1'b0; hp(Q);
    scl = 1'b0; hp(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; hp(Q);
    scl = 1'b1; hp(Q);
    sda_m = 1'b1; hp(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(Q);
      scl = 1'b1; hp(Q);
      scl = 1'b0;
    end
    sda_m = 1'b1; hp(Q);
    scl = 1'b1; hp(Q/2);
    ack = ~sda_bus; hp(Q/2);
    scl = 1'b0;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(Q);
      scl = 1'b1; hp(Q/2);
      b[i] = sda_bus; hp(Q/2);
      scl = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; hp(Q);
    scl = 1'b1; hp(Q);
    scl = 1'b0;
  endtask

  function automatic logic [7:0] mdl_rd();
    return (mptr == 15) ? {7'b0, mflag} : mdl[mptr];
  endfunction

  task automatic mdl_wr(input logic [7:0] d);
    if (mptr == 15) mflag = 0;
    else mdl[mptr] = d;
    mptr = (mptr + 1) % 16;
  endtask

  task automatic wr_seq(input logic [6:0] a, input logic [7:0] cmd,
                        input logic [7:0] d[$], input string tag);
    logic ack;
    do_start();
    wbyte({a, 1'b0}, ack);
    chk({tag, " address ack"}, ack, 1);
    wbyte(cmd, ack);
    chk({tag, " R7 command ack"}, ack, 1);
    mptr = cmd[3:0];
    foreach (d[k]) begin
      wbyte(d[k], ack);
      chk({tag, " R7 data ack"}, ack, 1);
      mdl_wr(d[k]);
    end
    do_stop();
  endtask

  task automatic rd_seq(input logic [6:0] a, input logic [7:0] cmd,
                        input int n, input string tag);
    logic ack;
    logic [7:0] b;
    do_start();
    wbyte({a, 1'b0}, ack);
    chk({tag, " address ack"}, ack, 1);
    wbyte(cmd, ack);
    chk({tag, " R7 command ack"}, ack, 1);
    mptr = cmd[3:0];
    do_rstart();
    wbyte({a, 1'b1}, ack);
    chk({tag, " R1 read address ack after repeated START"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i < n - 1, b);
      chk({tag, " R8 read data"}, b, mdl_rd());
      mptr = (mptr + 1) % 16;
    end
    quiet = 1;
    wbyte(8'hFF, ack);
    chk({tag, " R8 silent after NACK"}, ack, 0);
    do_stop();
    quiet = 0;
  endtask

  initial begin
    logic ack;
    logic [7:0] q3[$];
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    hp(10);
    rst_n = 1'b1;
    hp(5);
    chk("R10 sda_oe after reset", sda_oe, 0);

    q3 = '{8'hA5, 8'h3C, 8'h0F};
    wr_seq(7'h53, 8'h02, q3, "R3 own write");
    rd_seq(7'h53, 8'h02, 3, "R2 own read");

    // Unmatched address: no acknowledge and no bus activity.
    quiet = 1;
    do_start();
    wbyte({7'h50, 1'b0}, ack);
    chk("R5 unmatched address nack", ack, 0);
    wbyte(8'h02, ack);
    chk("R5 unmatched command nack", ack, 0);
    wbyte(8'h99, ack);
    chk("R5 unmatched data nack", ack, 0);
    do_stop();
    quiet = 0;
    rd_seq(7'h53, 8'h02, 1, "R5 register kept");

    q3 = '{8'h6E};
    wr_seq(7'h58, 8'h04, q3, "R4 broadcast write");
    rd_seq(7'h53, 8'h04, 1, "R4 broadcast readback");

    quiet = 1;
    do_start();
    wbyte({7'h58, 1'b1}, ack);
    chk("R4 broadcast read nack", ack, 0);
    do_stop();
    quiet = 0;

    q3 = '{8'h11, 8'h22, 8'h33};
    wr_seq(7'h53, 8'h0E, q3, "R11 wrap write");
    rd_seq(7'h53, 8'h0E, 3, "R11 wrap read");

    sel = 3'd7;
    hp(5);
    q3 = '{8'h44};
    wr_seq(7'h57, 8'h23, q3, "R7 command low bits");
    rd_seq(7'h57, 8'h03, 1, "R7 pointer from low bits");
    quiet = 1;
    do_start();
    wbyte({7'h53, 1'b0}, ack);
    chk("R3 old strap address nack", ack, 0);
    do_stop();
    quiet = 0;

    // Stuck SDA in the middle of a write.
    do_start();
    wbyte({7'h57, 1'b0}, ack);
    chk("R9 address ack before stuck bus", ack, 1);
    wbyte(8'h05, ack);
    chk("R9 command ack before stuck bus", ack, 1);
    sda_m = 1'b0;
    hp(TO + 500);
    mflag = 1;
    chk("R9 sda released after timeout", sda_oe, 0);
    sda_m = 1'b1; hp(Q);
    quiet = 1;
    wbyte(8'h77, ack);
    chk("R9 engine idle after timeout", ack, 0);
    do_stop();
    quiet = 0;
    rd_seq(7'h57, 8'h05, 1, "R9 no write after timeout");
    rd_seq(7'h57, 8'h0F, 1, "R9 status flag set");

    q3 = '{8'hFF};
    wr_seq(7'h57, 8'h0F, q3, "R12 status clear write");
    rd_seq(7'h57, 8'h0F, 1, "R12 status cleared");
    chk("R10 bus released at end", sda_oe, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule